// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the front end of a small 32-bit processor core. It holds the program counter and presents it on a combinational byte-read port. Each cycle the memory returns the six bytes that start at that address. The block splits the leading byte into an operation class and a variant code. It finds the instruction size from the operation class, pulls out two 4-bit register selectors and a 32-bit little-endian constant, and then moves the program counter past the instruction.

One decoded instruction comes out per cycle, qualified by a one-cycle strobe. A stop instruction is reported and then freezes fetching until reset. An unknown operation class or an unused variant freezes the counter at the offending address and raises a sticky error flag. Register selector 8 means "no register". The decoder reports it for forms that carry no register byte, and it passes it through where the instruction encoding places it.

Top module: `instr_fetch_decode`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, imem_addr_o is 0 and vld_o, halted_o and invalid_o are 0.
- R2: For a legal instruction, icode_o is bits 7:4 of byte 0 (imem_bytes_i[7:0]) and ifun_o is bits 3:0 of that byte. Each result is registered and appears one clock after the edge on which the fetch address was presented.
- R3: len_o is 1 for classes 0x0, 0x1 and 0x9. It is 2 for classes 0x2, 0x6, 0xA and 0xB. It is 5 for classes 0x7 and 0x8. It is 6 for classes 0x3, 0x4 and 0x5.
- R4: For 2-byte and 6-byte classes, ra_o is bits 7:4 of byte 1 and rb_o is bits 3:0 of byte 1, including the marker value 8 where the encoding places it. For 1-byte and 5-byte classes, both ra_o and rb_o are 8.
- R5: For classes 0x7 and 0x8, val_o is bytes 1..4 read as a little-endian word. For 6-byte classes, val_o is bytes 2..5 read as a little-endian word. For every other class, val_o is 0.
- R6: Each legal non-stop instruction raises vld_o for exactly one cycle and reports dec_pc_o as its own address and next_pc_o as that address plus len_o. On the same edge, imem_addr_o moves to next_pc_o, so back-to-back instructions decode on consecutive cycles.
- R7: A stop instruction (byte 0x10) raises vld_o once with icode_o = 1 and sets halted_o. From then until reset, imem_addr_o stays at the stop address and vld_o stays 0.
- R8: An instruction whose class is above 0xB, or whose variant is unused, sets invalid_o; vld_o stays 0 and imem_addr_o stays at that address until reset. The used variants are 0..3 for class 0x6, 0..6 for class 0x7, and only 0 for every other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | PC_W | Fetch address (program counter) |
| imem_bytes_i | input | 48 | Bytes at fetch address; byte k at bits 8k+7:8k |
| vld_o | output | 1 | One-cycle strobe for a decoded instruction |
| icode_o | output | 4 | Operation class |
| ifun_o | output | 4 | Variant code |
| ra_o | output | 4 | First register selector (8 = none) |
| rb_o | output | 4 | Second register selector (8 = none) |
| val_o | output | 32 | Decoded constant |
| len_o | output | 3 | Instruction size in bytes |
| dec_pc_o | output | PC_W | Address of the decoded instruction |
| next_pc_o | output | PC_W | Address after the decoded instruction |
| halted_o | output | 1 | Stop instruction seen |
| invalid_o | output | 1 | Illegal instruction seen |

## Verification
The bench builds the block with PC_W set to 12 and backs the fetch port with a 256-byte memory. Random programs of up to about 200 bytes therefore sweep every size class across unaligned addresses. With the narrower counter, address sums are checked against a width other than the default. Each program ends in a stop instruction or in one of several illegal encodings: high classes, an out-of-range arithmetic or jump variant, and a nonzero variant on a fixed class. In every case the freeze of the counter is observed.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int FETCH_BYTES = 6;
  localparam int VAL_BYTES   = 4;
  localparam int VAL_W       = 8 * VAL_BYTES;
  localparam int LEN_W       = 3;
  localparam logic [3:0] REG_NONE = 4'h8;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_HALT = 4'h1, OP_RRMV = 4'h2, OP_IRMV = 4'h3,
    OP_RMMV = 4'h4, OP_MRMV = 4'h5, OP_ALU  = 4'h6, OP_JMP  = 4'h7,
    OP_CALL = 4'h8, OP_RET  = 4'h9, OP_PUSH = 4'hA, OP_POP  = 4'hB
  } op_e;

  typedef struct packed {
    logic [3:0]       icode;
    logic [3:0]       ifun;
    logic [3:0]       ra;
    logic [3:0]       rb;
    logic [VAL_W-1:0] val;
    logic [LEN_W-1:0] len;
  } dec_t;
endpackage

// File: rtl/ifd_len_dec.sv
module ifd_len_dec
  import ifd_pkg::*;
(
  input  logic [3:0]       icode_i,
  input  logic [3:0]       ifun_i,
  output logic [LEN_W-1:0] len_o,
  output logic             legal_o
);
  always_comb begin
    len_o   = LEN_W'(1);
    legal_o = 1'b1;
    unique case (icode_i)
      OP_NOP, OP_HALT, OP_RET: len_o = LEN_W'(1);
      OP_RRMV, OP_ALU, OP_PUSH, OP_POP: len_o = LEN_W'(2);
      OP_JMP, OP_CALL: len_o = LEN_W'(5);
      OP_IRMV, OP_RMMV, OP_MRMV: len_o = LEN_W'(6);
      default: legal_o = 1'b0;
    endcase
    case (icode_i)
      OP_ALU:  if (ifun_i > 4'd3) legal_o = 1'b0;
      OP_JMP:  if (ifun_i > 4'd6) legal_o = 1'b0;
      default: if (ifun_i != 4'd0) legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ifd_field_ext.sv
module ifd_field_ext
  import ifd_pkg::*;
(
  input  logic [8*FETCH_BYTES-1:0] bytes_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [3:0]               ra_o,
  output logic [3:0]               rb_o,
  output logic [VAL_W-1:0]         val_o
);
  logic [VAL_W-1:0] val_short, val_long;

  // constant starts after opcode byte (5-byte) or after register byte (6-byte)
  for (genvar b = 0; b < VAL_BYTES; b++) begin : g_val
    assign val_short[8*b +: 8] = bytes_i[8*(b+1) +: 8];
    assign val_long [8*b +: 8] = bytes_i[8*(b+2) +: 8];
  end

  always_comb begin
    ra_o  = REG_NONE;
    rb_o  = REG_NONE;
    val_o = '0;
    case (len_i)
      LEN_W'(2): begin
        ra_o = bytes_i[15:12];
        rb_o = bytes_i[11:8];
      end
      LEN_W'(5): val_o = val_short;
      LEN_W'(6): begin
        ra_o  = bytes_i[15:12];
        rb_o  = bytes_i[11:8];
        val_o = val_long;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/instr_fetch_decode.sv
module instr_fetch_decode
  import ifd_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [PC_W-1:0]          imem_addr_o,
  input  logic [8*FETCH_BYTES-1:0] imem_bytes_i,
  output logic                     vld_o,
  output logic [3:0]               icode_o,
  output logic [3:0]               ifun_o,
  output logic [3:0]               ra_o,
  output logic [3:0]               rb_o,
  output logic [VAL_W-1:0]         val_o,
  output logic [LEN_W-1:0]         len_o,
  output logic [PC_W-1:0]          dec_pc_o,
  output logic [PC_W-1:0]          next_pc_o,
  output logic                     halted_o,
  output logic                     invalid_o
);
  logic [PC_W-1:0] pc_q, dec_pc_q, next_pc_q, pc_step;
  logic            vld_q, halted_q, invalid_q, legal;
  dec_t            dec_d, dec_q;

  assign dec_d.icode = imem_bytes_i[7:4];
  assign dec_d.ifun  = imem_bytes_i[3:0];

  ifd_len_dec u_len (
    .icode_i (dec_d.icode),
    .ifun_i  (dec_d.ifun),
    .len_o   (dec_d.len),
    .legal_o (legal)
  );

  ifd_field_ext u_fld (
    .bytes_i (imem_bytes_i),
    .len_i   (dec_d.len),
    .ra_o    (dec_d.ra),
    .rb_o    (dec_d.rb),
    .val_o   (dec_d.val)
  );

  assign pc_step = pc_q + PC_W'(dec_d.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      dec_pc_q  <= '0;
      next_pc_q <= '0;
      dec_q     <= '0;
      vld_q     <= 1'b0;
      halted_q  <= 1'b0;
      invalid_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!halted_q && !invalid_q) begin
        if (!legal) begin
          invalid_q <= 1'b1;
        end else begin
          vld_q     <= 1'b1;
          dec_q     <= dec_d;
          dec_pc_q  <= pc_q;
          next_pc_q <= pc_step;
          if (dec_d.icode == OP_HALT) halted_q <= 1'b1;
          else                        pc_q     <= pc_step;
        end
      end
    end
  end

  assign imem_addr_o = pc_q;
  assign vld_o       = vld_q;
  assign icode_o     = dec_q.icode;
  assign ifun_o      = dec_q.ifun;
  assign ra_o        = dec_q.ra;
  assign rb_o        = dec_q.rb;
  assign val_o       = dec_q.val;
  assign len_o       = dec_q.len;
  assign dec_pc_o    = dec_pc_q;
  assign next_pc_o   = next_pc_q;
  assign halted_o    = halted_q;
  assign invalid_o   = invalid_q;

  // R3
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (dec_q.len == 3'd1 || dec_q.len == 3'd2 || dec_q.len == 3'd5 || dec_q.len == 3'd6));

  // R6
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !halted_q) |-> (pc_q == $past(pc_q) + PC_W'(dec_q.len)));

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> ($stable(pc_q) && !vld_q && halted_q));

  // R7
  halt_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> (vld_q && dec_q.icode == 4'h1));

  // R8
  inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_q |=> ($stable(pc_q) && !vld_q && invalid_q));
endmodule

// File: tb/sim_instr_fetch_decode.sv
module sim_instr_fetch_decode;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] addr;
  logic [47:0]     bytes;
  logic            vld, halted, invalid;
  logic [3:0]      icode, ifun, ra, rb;
  logic [31:0]     val;
  logic [2:0]      len;
  logic [PC_W-1:0] dec_pc, next_pc;

  logic [7:0] mem [256];
  int errors = 0;
  int checks = 0;

  int          n_ins;
  int          wr_addr;
  logic [3:0]  e_ic [64];
  logic [3:0]  e_fn [64];
  logic [3:0]  e_ra [64];
  logic [3:0]  e_rb [64];
  logic [31:0] e_val [64];
  int          e_len [64];
  int          e_addr [64];

  always #4 clk = ~clk;

  always_comb
    for (int k = 0; k < 6; k++) bytes[8*k +: 8] = mem[8'(addr[7:0] + 8'(k))];

  instr_fetch_decode #(.PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(addr), .imem_bytes_i(bytes),
    .vld_o(vld), .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
    .val_o(val), .len_o(len), .dec_pc_o(dec_pc), .next_pc_o(next_pc),
    .halted_o(halted), .invalid_o(invalid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(logic [3:0] ic);
    case (ic)
      4'h0, 4'h1, 4'h9: return 1;
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      4'h7, 4'h8: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic put(logic [3:0] ic, logic [3:0] fn, logic [3:0] a, logic [3:0] b, logic [31:0] v);
    int l = blen(ic);
    int vo = (l == 5) ? 1 : 2;
    mem[wr_addr] = {ic, fn};
    if (l == 2 || l == 6) mem[wr_addr+1] = {a, b};
    if (l >= 5)
      for (int k = 0; k < 4; k++) mem[wr_addr+vo+k] = v[8*k +: 8];
    e_ic[n_ins]   = ic;
    e_fn[n_ins]   = fn;
    e_ra[n_ins]   = (l == 2 || l == 6) ? a : 4'h8;
    e_rb[n_ins]   = (l == 2 || l == 6) ? b : 4'h8;
    e_val[n_ins]  = (l >= 5) ? v : 32'h0;
    e_len[n_ins]  = l;
    e_addr[n_ins] = wr_addr;
    n_ins++;
    wr_addr += l;
  endtask

  task automatic build(bit directed);
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    n_ins = 0;
    wr_addr = 0;
    if (directed) begin
      put(4'h3, 4'h0, 4'h8, 4'h2, 32'h0000abcd);  // R4 R5 marker and LE constant
      put(4'h5, 4'h0, 4'h1, 4'h5, 32'hfffffff4);
      put(4'h7, 4'h3, 4'h0, 4'h0, 32'h00000123);
      put(4'hA, 4'h0, 4'h6, 4'h8, 32'h0);
    end
    while (wr_addr < 200 && n_ins < 60) begin
      logic [3:0] ic, fn, a, b;
      ic = 4'($urandom_range(0, 11));
      if (ic == 4'h1) ic = 4'h0;
      fn = 4'h0;
      if (ic == 4'h6) fn = 4'($urandom_range(0, 3));
      if (ic == 4'h7) fn = 4'($urandom_range(0, 6));
      a = 4'($urandom_range(0, 7));
      b = 4'($urandom_range(0, 7));
      if (ic == 4'h3) a = 4'h8;
      if (ic == 4'hA || ic == 4'hB) b = 4'h8;
      put(ic, fn, a, b, $urandom);
    end
  endtask

  task automatic run(bit end_halt, logic [7:0] bad);
    rst_n = 1'b0;
    if (end_halt) put(4'h1, 4'h0, 4'h0, 4'h0, 32'h0);
    else mem[wr_addr] = bad;
    #20;
    check("R1 addr", 64'(addr), 0);
    check("R1 flags", {vld, halted, invalid}, 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 after release", {vld, halted, invalid}, 0);
    for (int i = 0; i < n_ins; i++) begin
      @(posedge clk);
      #2;
      check("R6 vld", 64'(vld), 1);
      check("R2 icode/ifun", {icode, ifun}, {e_ic[i], e_fn[i]});
      check("R3 len", 64'(len), 64'(e_len[i]));
      check("R4 ra/rb", {ra, rb}, {e_ra[i], e_rb[i]});
      check("R5 val", 64'(val), 64'(e_val[i]));
      check("R6 dec_pc", 64'(dec_pc), 64'(e_addr[i]));
      check("R6 next_pc", 64'(next_pc), 64'(e_addr[i] + e_len[i]));
      if (end_halt && i == n_ins - 1) begin
        check("R7 halted", 64'(halted), 1);
        check("R7 addr held", 64'(addr), 64'(e_addr[i]));
      end else begin
        check("R6 addr", 64'(addr), 64'(e_addr[i] + e_len[i]));
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(posedge clk);
      #2;
      if (end_halt) begin
        check("R7 no strobe", 64'(vld), 0);
        check("R7 addr frozen", 64'(addr), 64'(e_addr[n_ins-1]));
        check("R7 halted", 64'(halted), 1);
      end else begin
        check("R8 no strobe", 64'(vld), 0);
        check("R8 invalid", 64'(invalid), 1);
        check("R8 addr frozen", 64'(addr), 64'(wr_addr));
      end
    end
  endtask

  initial begin
    logic [7:0] bads [6] = '{8'hC0, 8'hF0, 8'h64, 8'h77, 8'h21, 8'h91};
    void'($urandom(32'h5eed_1234));
    build(1'b1); run(1'b1, 8'h00);
    foreach (bads[k]) begin
      build(1'b0); run(1'b0, bads[k]);
    end
    build(1'b0); run(1'b1, 8'h00);
    // stop instruction first, at address 0
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    n_ins = 0; wr_addr = 0;
    run(1'b1, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule